// File: doc/BRIEF.md
# Truth-Table Multiplexer ALU

This is an 8-bit combinational ALU for an accumulator machine. One operand is always the accumulator; the other comes from the data bus. Every bit of the logic section is a 4:1 selector. The two operand bits for that bit position drive its select lines, and a 4-bit function code supplies its four data inputs. Any one of the sixteen two-input Boolean functions can therefore be applied bitwise, just by choosing the code.

The arithmetic section uses the same per-bit selector idea to condition both adder inputs. The accumulator side is either passed through or forced to zero. The bus side is either passed through or inverted. Two cascaded 4-bit nibble adders then form the sum, and the carry into the low nibble is forced for subtraction. The carry out of the top nibble is exported so that later condition logic can use it. The block has no clock and no shifter.

Top module: `tt_mux_alu`

## Requirements
- R1: In logic mode (op_kind = 2'b00), each result bit i equals fn_code[2*acc_a[i] + bus_b[i]]. Code bit 0 is used when both operand bits are 0, and code bit 3 is used when both are 1.
- R2: Every one of the 16 function codes gives its Boolean function bitwise. This includes 4'b0000 (zero), 4'b1000 (AND), 4'b1110 (OR), 4'b0110 (XOR), 4'b1100 (pass acc_a), 4'b1010 (pass bus_b), 4'b0011 (invert acc_a) and 4'b0101 (invert bus_b).
- R3: In logic mode, carry_out is 0.
- R4: In add mode (op_kind = 2'b01), {carry_out, result} equals acc_a + bus_b as a 9-bit sum.
- R5: In subtract mode (op_kind = 2'b10), {carry_out, result} equals acc_a + (255 - bus_b) + 1 modulo 512. Hence carry_out is 1 exactly when acc_a >= bus_b.
- R6: In load mode (op_kind = 2'b11), result equals bus_b and carry_out is 0, whatever the value of acc_a.
- R7: fn_code has no effect on result or carry_out in the add, subtract and load modes.
- R8: A carry out of the low nibble propagates into the high nibble. For example, 8'h0F + 8'h01 gives 8'h10 with carry_out 0, and 8'hFF + 8'h01 gives 8'h00 with carry_out 1.
- R9: The block is purely combinational: both outputs reflect the present inputs with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_a | input | 8 | Accumulator operand |
| bus_b | input | 8 | Bus operand |
| op_kind | input | 2 | 00 logic, 01 add, 10 subtract, 11 load |
| fn_code | input | 4 | Truth-table pattern used in logic mode |
| result | output | 8 | ALU result |
| carry_out | output | 1 | Carry out of the high nibble |

## Verification
Both outputs are due in the same cycle as the inputs that produce them, with zero register stages. The bench changes the inputs one time unit after a rising clock edge. It samples on the following falling edge, so each comparison sees settled outputs from one stimulus only. Expected values are built from sums of minterms for the logic codes and from integer addition for the arithmetic modes.

// File: rtl/tt_mux_alu.sv
module tt_mux_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_a,
  input  logic [W-1:0] bus_b,
  input  logic [1:0]   op_kind,
  input  logic [3:0]   fn_code,
  output logic [W-1:0] result,
  output logic         carry_out
);
  localparam int NIB = W / 4;
  localparam logic [3:0] PAT_ZERO = 4'b0000;
  localparam logic [3:0] PAT_A    = 4'b1100;
  localparam logic [3:0] PAT_B    = 4'b1010;
  localparam logic [3:0] PAT_NB   = 4'b0101;

  logic [3:0]   pat_x, pat_y;
  logic         cin;
  logic [W-1:0] lu, xa, yb, sum;
  logic [NIB:0] c;
  logic         is_logic;

  always_comb begin
    pat_x = PAT_ZERO;
    pat_y = PAT_ZERO;
    cin   = 1'b0;
    case (op_kind)
      2'b01: begin pat_x = PAT_A;    pat_y = PAT_B;  end
      2'b10: begin pat_x = PAT_A;    pat_y = PAT_NB; cin = 1'b1; end
      2'b11: begin pat_x = PAT_ZERO; pat_y = PAT_B;  end
      default: ;
    endcase
  end

  for (genvar i = 0; i < W; i++) begin : g_slice
    assign lu[i] = fn_code[{acc_a[i], bus_b[i]}];
    assign xa[i] = pat_x[{acc_a[i], bus_b[i]}];
    assign yb[i] = pat_y[{acc_a[i], bus_b[i]}];
  end

  assign c[0] = cin;
  for (genvar n = 0; n < NIB; n++) begin : g_nib
    assign {c[n+1], sum[4*n +: 4]} = {1'b0, xa[4*n +: 4]} + {1'b0, yb[4*n +: 4]} + {4'b0000, c[n]};
  end

  assign is_logic  = (op_kind == 2'b00);
  assign result    = is_logic ? lu : sum;
  assign carry_out = is_logic ? 1'b0 : c[NIB];

  always_comb begin
    // R2
    if (op_kind == 2'b00 && fn_code == 4'b1000)
      and_fn_chk: assert (result == (acc_a & bus_b)) else $error("and function wrong");
    // R2
    if (op_kind == 2'b00 && fn_code == 4'b0110)
      xor_fn_chk: assert (result == (acc_a ^ bus_b)) else $error("xor function wrong");
    // R3
    if (op_kind == 2'b00)
      logic_carry_chk: assert (!carry_out) else $error("carry set in logic mode");
    // R4
    if (op_kind == 2'b01)
      add_sum_chk: assert ({carry_out, result} == ({1'b0, acc_a} + {1'b0, bus_b}))
        else $error("add sum wrong");
    // R5
    if (op_kind == 2'b10)
      sub_diff_chk: assert ({carry_out, result} == ({1'b0, acc_a} + {1'b0, ~bus_b} + (W+1)'(1)))
        else $error("subtract wrong");
    // R6
    if (op_kind == 2'b11)
      load_pass_chk: assert (result == bus_b && !carry_out) else $error("load wrong");
  end
endmodule

// File: tb/tt_mux_alu_tb_top.sv
module tt_mux_alu_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] acc_a, bus_b, result;
  logic [1:0] op_kind;
  logic [3:0] fn_code;
  logic       carry_out;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  tt_mux_alu #(.W(8)) dut_i (
    .acc_a(acc_a), .bus_b(bus_b), .op_kind(op_kind), .fn_code(fn_code),
    .result(result), .carry_out(carry_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected <= 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic logic [7:0] minterms(input logic [3:0] f, input logic [7:0] a, input logic [7:0] b);
    return (f[0] ? (~a & ~b) : 8'h00) | (f[1] ? (~a & b) : 8'h00) |
           (f[2] ? (a & ~b) : 8'h00)  | (f[3] ? (a & b) : 8'h00);
  endfunction

  task automatic run(input string req, input logic [1:0] k, input logic [3:0] f,
                     input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] er, input logic ec);
    @(posedge clk); #1;
    acc_a = a; bus_b = b; op_kind = k; fn_code = f;
    @(negedge clk);
    checks++;
    if (result !== er || carry_out !== ec) begin
      errors++;
      $display("FAIL %s: k=%0d f=%h a=%h b=%h actual=%b/%h expected=%b/%h",
               req, k, f, a, b, carry_out, result, ec, er);
    end
  endtask

  initial begin
    int s;
    acc_a = 0; bus_b = 0; op_kind = 0; fn_code = 0;
    // R9 initial settled state: all-zero inputs give zero outputs
    run("R9", 2'b00, 4'h0, 8'h00, 8'h00, 8'h00, 1'b0);
    // R2 named codes
    run("R2", 2'b00, 4'b1000, 8'hF0, 8'hCC, 8'hC0, 1'b0);
    run("R2", 2'b00, 4'b1110, 8'hF0, 8'hCC, 8'hFC, 1'b0);
    run("R2", 2'b00, 4'b0110, 8'hF0, 8'hCC, 8'h3C, 1'b0);
    run("R2", 2'b00, 4'b1100, 8'hF0, 8'hCC, 8'hF0, 1'b0);
    run("R2", 2'b00, 4'b1010, 8'hF0, 8'hCC, 8'hCC, 1'b0);
    run("R2", 2'b00, 4'b0011, 8'hF0, 8'hCC, 8'h0F, 1'b0);
    run("R2", 2'b00, 4'b0101, 8'hF0, 8'hCC, 8'h33, 1'b0);
    // R1 R3 all codes over an operand sweep
    for (int f = 0; f < 16; f++)
      for (int a = 0; a < 256; a++) begin
        s = (a * 29 + 7 + f * 11) & 255;
        run("R1/R3", 2'b00, 4'(f), 8'(a), 8'(s), minterms(4'(f), 8'(a), 8'(s)), 1'b0);
      end
    // R8 nibble carry boundaries
    run("R8", 2'b01, 4'h0, 8'h0F, 8'h01, 8'h10, 1'b0);
    run("R8", 2'b01, 4'h0, 8'hFF, 8'h01, 8'h00, 1'b1);
    run("R8", 2'b10, 4'h0, 8'h10, 8'h01, 8'h0F, 1'b1);
    // R5 boundaries
    run("R5", 2'b10, 4'h0, 8'h00, 8'h01, 8'hFF, 1'b0);
    run("R5", 2'b10, 4'h0, 8'h42, 8'h42, 8'h00, 1'b1);
    // R4 R5 R6 R7 sweeps with varying fn_code
    for (int a = 0; a < 256; a++)
      for (int j = 0; j < 16; j++) begin
        int b, sm, df;
        b  = (j * 17 + a * 3) & 255;
        sm = a + b;
        df = a + (255 - b) + 1;
        run("R4/R7", 2'b01, 4'(j ^ a), 8'(a), 8'(b), 8'(sm), sm[8]);
        run("R5/R7", 2'b10, 4'(j + a), 8'(a), 8'(b), 8'(df), df[8]);
        run("R6/R7", 2'b11, 4'(j), 8'(a), 8'(b), 8'(b), 1'b0);
      end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule